// File: doc/BRIEF.md
# Flash Erase and Program Sequencer

This block sits on the host side of an asynchronous parallel flash. It takes one operation at a time on a valid/ready request port: either erase the block that holds an address, or program one byte at an address. Longer byte runs are issued as back-to-back program requests. For each request it drives the two-cycle command sequence on the flash bus, then reads the status byte over and over until the device reports ready. It then decodes the error bits in a fixed priority order and returns a result code with a one-cycle `done` pulse. When an error is found, it writes the clear-status command before reporting.

While the device is busy, the host may pulse `susp_req`. The sequencer writes the suspend command and waits for ready. It then looks at the suspend-status bit that belongs to the running operation, which is bit 6 for an erase and bit 2 for a program.

- **Bit set.** The sequencer switches the device to array reads and reports "suspended". The host may then read the array until it pulses `resume_req`, and the operation continues to a normal finish.
- **Bit clear.** The operation had already finished. The sequencer never resumes it and reports its full status check instead.

Every bus phase length and the poll limit are parameters.

Top module: `flseq_top`

## Requirements
- R1: While `rst_n` is low, `fl_rst_n` is low, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high and `done` is low. After reset `fl_rst_n` is high and `req_ready` is high.
- R2: An erase request (`req_op`=0) writes 20h and then D0h, both at `req_addr`. It then reads status until bit 7 reads 1.
- R3: A program request (`req_op`=1) writes 40h and then `req_data`, both at `req_addr`. It then polls status bit 7 in the same way.
- R4: Each bus write passes through three phases:
  - a setup phase of `T_SU` clocks with CE and WE high;
  - exactly `T_WE` clocks with both `fl_ce_n` and `fl_we_n` low;
  - a hold phase of `T_HD` clocks.

  `fl_addr` and `fl_dout` stay unchanged from the first low clock until the hold phase.
- R5: The result is decoded from the final status byte in this order:
  - bit 3 set gives 1 (voltage error);
  - else bit 1 set gives 2 (protect error);
  - else bits 4 and 5 both set gives 3 (sequence error);
  - else the operation bit set gives 4 (operation error). The operation bit is bit 5 for an erase and bit 4 for a program;
  - else the result is 0 (ok).

  Every result is given on `result` with a one-clock `done` pulse.
- R6: When the result is 1 to 4, the command 50h is written before `done`. For result 0 no 50h is written.
- R7: After `POLL_LIMIT` consecutive status reads with bit 7 at 0, the block ends with result 5 (timeout).
- R8: A `susp_req` pulse while status is being polled makes the block write B0h and poll until ready. If the suspend bit of the operation is set (bit 6 for an erase, bit 2 for a program), it then writes FFh and reports result 6 (suspended).
- R9: If that suspend bit reads 0, neither FFh nor D0h is written. The result is the full status check of R5 and R6.
- R10: In the suspended state, a `resume_req` pulse writes D0h. Polling then restarts and ends in a normal result.
- R11: `req_ready` is high only when the block is idle. A `susp_req` or `resume_req` outside its state causes no bus write and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request accepted when both high |
| req_op | input | 1 | 0 erase block, 1 program byte |
| req_addr | input | AW | Target address (any address in the block for erase) |
| req_data | input | 8 | Byte to program |
| susp_req | input | 1 | Suspend pulse, honoured while polling |
| resume_req | input | 1 | Resume pulse, honoured while suspended |
| done | output | 1 | One-clock completion pulse |
| result | output | 3 | 0 ok, 1 voltage, 2 protect, 3 sequence, 4 operation, 5 timeout, 6 suspended |
| fl_rst_n | output | 1 | Flash reset, low during system reset |
| fl_ce_n | output | 1 | Flash chip enable |
| fl_we_n | output | 1 | Flash write enable |
| fl_oe_n | output | 1 | Flash output enable |
| fl_addr | output | AW | Flash address |
| fl_dout | output | 8 | Data driven toward the flash |
| fl_din | input | 8 | Data read from the flash |
| fl_dq_oe | output | 1 | High while the block drives the data lines |

## Verification
The bench goes after the error priority order, with these status bytes:
- 28h must give a voltage error, not an operation error;
- 22h must give a protect error;
- 30h must give a sequence error, not an operation error;
- 20h on a program must be ok, because bit 5 belongs to erase.

A wrong decoder would report the lower-priority code. It would also skip or add the clear-status write.

Suspend is driven both ways. A design that ignored the suspend bit would write FFh and D0h to an operation that had already finished. A design that never honoured the request would run straight through without reporting a suspension.

A device that never becomes ready must end in a timeout instead of hanging. Every write pulse is measured for its width and for address and data stability.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_VPP     = 3'd1,
    RES_PROT    = 3'd2,
    RES_SEQ     = 3'd3,
    RES_OPERR   = 3'd4,
    RES_TIMEOUT = 3'd5,
    RES_SUSP    = 3'd6
  } flseq_res_e;

  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_SUSP    = 8'hB0;
  localparam logic [7:0] CMD_CLRST   = 8'h50;
  localparam logic [7:0] CMD_RDARR   = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_CMD2, S_POLL, S_CHECK, S_CLR,
    S_SUSP_WR, S_SUSP_POLL, S_RDARR, S_HALT, S_RESUME
  } flseq_state_e;

  typedef enum logic [1:0] {PH_IDLE, PH_SU, PH_ACT, PH_HD} flseq_phase_e;

endpackage

// File: rtl/flseq_stat_dec.sv
module flseq_stat_dec
  import flseq_pkg::*;
(
  input  logic [7:0] stat,
  input  logic       is_erase,
  output logic [2:0] code
);
  logic op_bit;

  always_comb begin
    op_bit = is_erase ? stat[5] : stat[4];
    if (stat[3])                 code = RES_VPP;
    else if (stat[1])            code = RES_PROT;
    else if (stat[4] && stat[5]) code = RES_SEQ;
    else if (op_bit)             code = RES_OPERR;
    else                         code = RES_OK;
  end
endmodule

// File: rtl/flseq_buscyc.sv
module flseq_buscyc
  import flseq_pkg::*;
#(
  parameter int AW   = 21,
  parameter int T_SU = 1,
  parameter int T_WE = 3,
  parameter int T_HD = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          busy,
  output logic          cyc_done,
  output logic [7:0]    rdata,
  input  logic [7:0]    fl_din,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dout,
  output logic          fl_dq_oe,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  localparam int TMAX = (T_SU > T_WE) ? ((T_SU > T_HD) ? T_SU : T_HD)
                                      : ((T_WE > T_HD) ? T_WE : T_HD);
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] SU_LAST = CW'(T_SU - 1);
  localparam logic [CW-1:0] WE_LAST = CW'(T_WE - 1);
  localparam logic [CW-1:0] HD_LAST = CW'(T_HD - 1);

  flseq_phase_e  ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_q;
  logic          load_en, cap_en;

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    cap_en  = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start) begin
        ph_d = PH_SU; cnt_d = '0; load_en = 1'b1;
      end
      PH_SU: if (cnt_q == SU_LAST) begin
        ph_d = PH_ACT; cnt_d = '0;
      end else cnt_d = cnt_q + 1'b1;
      PH_ACT: if (cnt_q == WE_LAST) begin
        ph_d = PH_HD; cnt_d = '0; cap_en = ~wr_q;
      end else cnt_d = cnt_q + 1'b1;
      PH_HD: if (cnt_q == HD_LAST) begin
        ph_d = PH_IDLE; cnt_d = '0;
      end else cnt_d = cnt_q + 1'b1;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      fl_addr <= '0;
      fl_dout <= '0;
      rdata   <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (load_en) begin
        wr_q    <= wr;
        fl_addr <= addr_i;
        fl_dout <= data_i;
      end
      if (cap_en) rdata <= fl_din;
    end
  end

  assign busy     = (ph_q != PH_IDLE);
  assign cyc_done = (ph_q == PH_HD) && (cnt_q == HD_LAST);
  assign fl_ce_n  = (ph_q != PH_ACT);
  assign fl_we_n  = !((ph_q == PH_ACT) && wr_q);
  assign fl_oe_n  = !((ph_q == PH_ACT) && !wr_q);
  assign fl_dq_oe = busy && wr_q;

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> !fl_ce_n); // R4
  AST_WR_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |=> ($stable(fl_addr) && $stable(fl_dout))); // R4
endmodule

// File: rtl/flseq_top.sv
module flseq_top
  import flseq_pkg::*;
#(
  parameter int AW         = 21,
  parameter int T_SU       = 1,
  parameter int T_WE       = 3,
  parameter int T_HD       = 1,
  parameter int POLL_LIMIT = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          susp_req,
  input  logic          resume_req,
  output logic          done,
  output logic [2:0]    result,
  output logic          fl_rst_n,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dout,
  input  logic [7:0]    fl_din,
  output logic          fl_dq_oe
);
  localparam int PCW = $clog2(POLL_LIMIT + 1);
  localparam logic [PCW-1:0] POLL_LAST = PCW'(POLL_LIMIT - 1);

  flseq_state_e  st_q, st_d;
  logic          erase_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q, stat_q, stat_d;
  logic [PCW-1:0] poll_q, poll_d;
  logic          spend_q, spend_d;
  logic          done_d;
  logic [2:0]    res_d, res_q;
  logic          acc_en;

  logic          bus_issue, bus_wr, bus_busy, bus_done, bus_start;
  logic [7:0]    bus_data, bus_rdata;
  logic [2:0]    dec_code;
  logic          susp_bit;

  flseq_buscyc #(.AW(AW), .T_SU(T_SU), .T_WE(T_WE), .T_HD(T_HD)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(bus_start), .wr(bus_wr),
    .addr_i(addr_q), .data_i(bus_data), .busy(bus_busy), .cyc_done(bus_done),
    .rdata(bus_rdata), .fl_din(fl_din), .fl_addr(fl_addr), .fl_dout(fl_dout),
    .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  flseq_stat_dec u_dec (.stat(stat_q), .is_erase(erase_q), .code(dec_code));

  // command selection per state
  always_comb begin
    bus_issue = 1'b1;
    bus_wr    = 1'b1;
    bus_data  = 8'h00;
    unique case (st_q)
      S_CMD1:      bus_data = erase_q ? CMD_ERASE : CMD_PROG;
      S_CMD2:      bus_data = erase_q ? CMD_CONFIRM : data_q;
      S_POLL,
      S_SUSP_POLL: bus_wr   = 1'b0;
      S_CLR:       bus_data = CMD_CLRST;
      S_SUSP_WR:   bus_data = CMD_SUSP;
      S_RDARR:     bus_data = CMD_RDARR;
      S_RESUME:    bus_data = CMD_CONFIRM;
      default:     begin bus_issue = 1'b0; bus_wr = 1'b0; end
    endcase
  end

  assign bus_start = bus_issue && !bus_busy;
  assign req_ready = (st_q == S_IDLE);
  assign acc_en    = req_ready && req_valid;
  assign susp_bit  = erase_q ? bus_rdata[6] : bus_rdata[2];

  always_comb begin
    st_d    = st_q;
    poll_d  = poll_q;
    spend_d = spend_q;
    stat_d  = stat_q;
    done_d  = 1'b0;
    res_d   = res_q;
    unique case (st_q)
      S_IDLE:   if (req_valid) st_d = S_CMD1;
      S_CMD1:   if (bus_done) st_d = S_CMD2;
      S_CMD2, S_RESUME: if (bus_done) begin
        st_d = S_POLL; poll_d = '0; spend_d = 1'b0;
      end
      S_POLL: begin
        if (susp_req) spend_d = 1'b1;
        if (bus_done) begin
          stat_d = bus_rdata;
          if (bus_rdata[7]) st_d = S_CHECK;
          else if (spend_q || susp_req) begin
            st_d = S_SUSP_WR; poll_d = '0; spend_d = 1'b0;
          end else if (poll_q == POLL_LAST) begin
            st_d = S_IDLE; done_d = 1'b1; res_d = RES_TIMEOUT;
          end else poll_d = poll_q + 1'b1;
        end
      end
      S_SUSP_WR: if (bus_done) st_d = S_SUSP_POLL;
      S_SUSP_POLL: if (bus_done) begin
        stat_d = bus_rdata;
        if (bus_rdata[7]) st_d = susp_bit ? S_RDARR : S_CHECK;
        else if (poll_q == POLL_LAST) begin
          st_d = S_IDLE; done_d = 1'b1; res_d = RES_TIMEOUT;
        end else poll_d = poll_q + 1'b1;
      end
      S_CHECK: begin
        res_d = dec_code;
        if (dec_code == RES_OK) begin
          st_d = S_IDLE; done_d = 1'b1;
        end else st_d = S_CLR;
      end
      S_CLR: if (bus_done) begin st_d = S_IDLE; done_d = 1'b1; end
      S_RDARR: if (bus_done) begin
        st_d = S_HALT; done_d = 1'b1; res_d = RES_SUSP;
      end
      S_HALT: if (resume_req) st_d = S_RESUME;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      poll_q   <= '0;
      spend_q  <= 1'b0;
      stat_q   <= '0;
      done     <= 1'b0;
      res_q    <= '0;
      erase_q  <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      fl_rst_n <= 1'b0;
    end else begin
      st_q     <= st_d;
      poll_q   <= poll_d;
      spend_q  <= spend_d;
      stat_q   <= stat_d;
      done     <= done_d;
      res_q    <= res_d;
      fl_rst_n <= 1'b1;
      if (acc_en) begin
        erase_q <= ~req_op;
        addr_q  <= req_addr;
        data_q  <= req_data;
      end
    end
  end

  assign result = res_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_RESULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != 3'd7)); // R5
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_ce_n && fl_we_n)); // R11
  AST_HALT_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_HALT) |-> fl_ce_n); // R8
  AST_FLRST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> fl_rst_n); // R1
endmodule

// File: tb/tb_flseq_top.sv
module tb_flseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 21;
  localparam int T_SU = 2;
  localparam int T_WE = 3;
  localparam int T_HD = 2;
  localparam int PLIM = 100;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_op;
  logic [AW-1:0] req_addr;
  logic [7:0] req_data;
  logic susp_req, resume_req, done;
  logic [2:0] result;
  logic fl_rst_n, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dout, fl_din;

  always #(CLK_PERIOD/2) clk = ~clk;

  flseq_top #(.AW(AW), .T_SU(T_SU), .T_WE(T_WE), .T_HD(T_HD), .POLL_LIMIT(PLIM)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .susp_req(susp_req), .resume_req(resume_req), .done(done), .result(result),
    .fl_rst_n(fl_rst_n), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din), .fl_dq_oe(fl_dq_oe)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0]    m_stat;
  logic          m_busy, m_susp, m_erase;
  logic [1:0]    m_pend;
  int            m_cnt;
  int            busy_len = 40;
  logic [7:0]    err_bits = 8'h00;
  bit            never_ready = 0;
  bit            finish_first = 0;
  logic          prev_we;
  logic [7:0]    log_d[$];
  logic [AW-1:0] log_a[$];

  assign fl_din = m_stat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat <= 8'h80; m_busy <= 0; m_susp <= 0; m_erase <= 0;
      m_pend <= 0; m_cnt <= 0; prev_we <= 1;
    end else begin
      prev_we <= fl_we_n;
      if (m_busy && !never_ready) begin
        if (m_cnt == 0) begin m_stat <= 8'h80 | err_bits; m_busy <= 0; end
        else m_cnt <= m_cnt - 1;
      end
      if (!prev_we && fl_we_n) begin
        log_d.push_back(fl_dout);
        log_a.push_back(fl_addr);
        if (m_pend != 0) begin
          m_pend <= 0;
          if (m_pend == 2 || fl_dout == 8'hD0) begin
            m_busy <= 1; m_cnt <= busy_len; m_stat <= 8'h00; m_erase <= (m_pend == 1);
          end
        end else begin
          case (fl_dout)
            8'h20: m_pend <= 1;
            8'h40: m_pend <= 2;
            8'hB0: if (m_busy) begin
              if (finish_first) m_stat <= 8'h80 | err_bits;
              else begin
                m_susp <= 1;
                m_stat <= m_erase ? 8'hC0 : 8'h84;
              end
              m_busy <= 0;
            end
            8'hD0: if (m_susp) begin
              m_susp <= 0; m_busy <= 1; m_stat <= 8'h00;
            end
            8'h50: m_stat <= m_stat & 8'hC5;
            default: ;
          endcase
        end
      end
    end
  end

  // ---------------- scoreboard monitor ----------------
  int exp_q[$];
  int done_seen = 0;

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected done", result, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(result == e, "R5/R7/R8 result code", result, e);
      end
      done_seen++;
    end
  end

  // ---------------- write pulse monitor (R4) ----------------
  int we_len = 0;
  int hold_left = 0;
  logic [AW-1:0] cap_a;
  logic [7:0] cap_d;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!fl_we_n) begin
        if (we_len == 0) begin cap_a = fl_addr; cap_d = fl_dout; end
        else chk(fl_addr == cap_a && fl_dout == cap_d, "R4 bus stable in pulse", fl_addr, cap_a);
        if (fl_ce_n) chk(0, "R4 ce low with we", fl_ce_n, 0);
        we_len++;
      end else if (we_len != 0) begin
        chk(we_len == T_WE, "R4 we low width", we_len, T_WE);
        chk(fl_addr == cap_a && fl_dout == cap_d, "R4 hold after we rise", fl_dout, cap_d);
        we_len = 0;
      end
    end
  end

  // ---------------- driver ----------------
  task automatic start_op(input logic op, input logic [AW-1:0] a, input logic [7:0] d, input int exp);
    exp_q.push_back(exp);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_data = d;
    do @(posedge clk); while (!req_ready);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(input int n);
    while (done_seen < n) @(negedge clk);
  endtask

  task automatic clear_log();
    log_d.delete(); log_a.delete();
  endtask

  task automatic pulse(input bit which_susp);
    @(negedge clk);
    if (which_susp) susp_req = 1; else resume_req = 1;
    @(negedge clk);
    susp_req = 0; resume_req = 0;
  endtask

  task automatic err_case(input logic op, input logic [7:0] eb, input int exp, input string tag);
    int n;
    err_bits = eb;
    clear_log();
    n = done_seen + 1;
    start_op(op, 21'h0_4000, 8'h3C, exp);
    wait_done(n);
    repeat (4) @(negedge clk);
    if (exp != 0) begin
      chk(log_d.size() == 3 && log_d[2] == 8'h50, {tag, " R6 clear status"}, log_d.size(), 3);
    end else begin
      chk(log_d.size() == 2, {tag, " R6 no clear on ok"}, log_d.size(), 2);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 0; req_valid = 0; req_op = 0; req_addr = '0; req_data = '0;
    susp_req = 0; resume_req = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(fl_rst_n == 0, "R1 fl_rst_n low in reset", fl_rst_n, 0);
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R1 bus idle in reset", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
    chk(done == 0, "R1 done low in reset", done, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(fl_rst_n == 1, "R1 fl_rst_n high after reset", fl_rst_n, 1);
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);

    // R2 erase ok
    clear_log(); err_bits = 0;
    n = done_seen + 1;
    start_op(0, 21'h1A_2345, 8'h00, 0);
    wait_done(n);
    chk(log_d.size() == 2, "R2 erase write count", log_d.size(), 2);
    chk(log_d[0] == 8'h20 && log_d[1] == 8'hD0, "R2 erase commands", {log_d[0], log_d[1]}, 16'h20D0);
    chk(log_a[0] == 21'h1A_2345 && log_a[1] == 21'h1A_2345, "R2 erase address", log_a[1], 21'h1A_2345);

    // R3 program ok
    clear_log();
    n = done_seen + 1;
    start_op(1, 21'h00_0077, 8'hA5, 0);
    wait_done(n);
    chk(log_d.size() == 2 && log_d[0] == 8'h40 && log_d[1] == 8'hA5, "R3 program sequence",
        log_d.size() == 2 ? {log_d[0], log_d[1]} : 0, 16'h40A5);
    chk(log_a[1] == 21'h00_0077, "R3 program address", log_a[1], 21'h77);

    // R5/R6 priority order
    err_case(0, 8'h28, 1, "R5 voltage over op");
    err_case(0, 8'h22, 2, "R5 protect over op");
    err_case(0, 8'h30, 3, "R5 sequence");
    err_case(0, 8'h20, 4, "R5 erase op bit");
    err_case(1, 8'h10, 4, "R5 program op bit");
    err_case(1, 8'h20, 0, "R5 erase bit on program");
    err_bits = 0;

    // R7 timeout
    never_ready = 1; clear_log();
    n = done_seen + 1;
    start_op(0, 21'h0, 8'h0, 5);
    wait_done(n);
    chk(log_d.size() == 2, "R7 no extra writes on timeout", log_d.size(), 2);
    never_ready = 0;
    repeat (60) @(negedge clk);

    // R8 / R10 suspend then resume
    busy_len = 300; clear_log();
    n = done_seen + 1;
    start_op(0, 21'h05_0000, 8'h0, 6);
    repeat (60) @(negedge clk);
    pulse(1);
    wait_done(n);
    repeat (4) @(negedge clk);
    chk(log_d.size() == 4 && log_d[2] == 8'hB0 && log_d[3] == 8'hFF, "R8 suspend writes",
        log_d.size(), 4);
    chk(req_ready == 0, "R11 not ready while suspended", req_ready, 0);
    n = done_seen + 1;
    exp_q.push_back(0);
    pulse(0);
    wait_done(n);
    chk(log_d.size() == 5 && log_d[4] == 8'hD0, "R10 resume write", log_d.size(), 5);

    // R9 already complete at suspend
    busy_len = 300; finish_first = 1; clear_log();
    n = done_seen + 1;
    start_op(1, 21'h00_1234, 8'h5A, 0);
    repeat (60) @(negedge clk);
    pulse(1);
    wait_done(n);
    repeat (10) @(negedge clk);
    chk(log_d.size() == 3 && log_d[2] == 8'hB0, "R9 no read-array or resume", log_d.size(), 3);
    finish_first = 0; busy_len = 40;

    // R11 stray pulses while idle
    clear_log();
    n = done_seen;
    pulse(0);
    pulse(1);
    repeat (20) @(negedge clk);
    chk(log_d.size() == 0, "R11 no write on stray pulses", log_d.size(), 0);
    chk(done_seen == n, "R11 no done on stray pulses", done_seen, n);
    chk(req_ready == 1, "R11 ready stays high", req_ready, 1);

    chk(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule